// File: doc/BRIEF.md
# CAN Receive Acceptance and Buffering Unit

This unit sits behind a CAN deserializer that has already removed stuffing, checked the CRC and split each frame into a header (11-bit identifier and data length code) and a stream of data bytes. For every header it decides whether the frame is wanted. It then presents the accepted frame to the processor through a small set of read-only registers. The acceptance test compares only the seven most significant identifier bits with a programmed value. A separate accept-all control bypasses that comparison. Rejected frames are dropped without leaving any trace in the visible registers.

Data bytes of an accepted frame are delivered through two alternating registers: one receives the 1st, 3rd, 5th and 7th bytes, and the other receives the 2nd, 4th, 6th and 8th. A byte-ready flag tells the processor that a fresh pair can be collected. An overrun bit records that a pair was overwritten before it was read. Bit values are stored exactly as received: a dominant bus level is 0 and a recessive level is 1.

Top module: `can_rx_accept`

## Requirements
- R1: After reset, the five readable registers read 0, `byte_rdy` is 0, and the filter value and accept-all bit are 0. With these settings, only frames whose identifier bits 10..4 are all zero are accepted.
- R2: A header with accept-all at 0 is accepted when `hdr_id[10:4]` equals the filter value. From the next cycle, address 3 reads `{1'b0, id[10:4]}` and address 2 reads `{id[3:0], dlc}`.
- R3: When the accept-all bit is 1, every header is accepted, whatever its identifier.
- R4: A rejected header and the bytes that follow it leave all five registers and `byte_rdy` unchanged.
- R5: The 1st, 3rd, 5th and 7th data bytes of an accepted frame are loaded into address 0. The 2nd, 4th, 6th and 8th are loaded into address 1.
- R6: `byte_rdy` (also status bit 0) rises in the cycle after an even-numbered byte is loaded. It also rises after the final byte of a frame with an odd byte count.
- R7: A read strobe (`rd_en`) at address 1 clears `byte_rdy`. Reads at any other address, and changes of `rd_addr` alone, have no effect.
- R8: Status bit 1 (overrun) is set when a pair completes while `byte_rdy` is still pending and is not being cleared in the same cycle. A read strobe at address 4 clears it. Status bits 7..2 read 0, and addresses 5 to 7 read 0.
- R9: A length code above 8 is stored unchanged in address 2 but allows only 8 bytes. Bytes beyond the frame's byte count are ignored.
- R10: A header in the same cycle as a byte discards the byte. A configuration write takes effect for headers from the next cycle on. When a pair completes in the same cycle as a clearing read, the ready flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads filter value and accept-all bit |
| cfg_filter | input | 7 | Value compared with identifier bits 10..4 |
| cfg_accept_all | input | 1 | 1 accepts every frame |
| hdr_vld | input | 1 | Header strobe from the deserializer |
| hdr_id | input | 11 | Received identifier |
| hdr_dlc | input | 4 | Received data length code |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Received data byte |
| rd_en | input | 1 | Read strobe, gives clear-on-read side effects |
| rd_addr | input | 3 | Register select: 0 odd data, 1 even data, 2 id-low/length, 3 id-high, 4 status |
| rd_data | output | 8 | Selected register, combinational from `rd_addr` |
| byte_rdy | output | 1 | A data pair is waiting |

## Verification
Every register and flag change lands exactly one clock edge after the strobe that causes it. `rd_data` is a combinational view of that state, so a result is due in the cycle after the strobe and no later. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge, and one nanosecond later `rd_data` and `byte_rdy` are compared with the model on every cycle. Directed checks read registers through idle cycles with the read strobe low, so looking at a register never clears it.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

   // CPU-visible register selects
   typedef enum logic [2:0] {
      RA_DATA_ODD  = 3'd0,
      RA_DATA_EVEN = 3'd1,
      RA_ID_LO     = 3'd2,
      RA_ID_HI     = 3'd3,
      RA_STAT      = 3'd4
   } rx_addr_e;

   localparam int ST_RDY_BIT = 0;
   localparam int ST_OVR_BIT = 1;

   // Byte-slot steering produced by the sequencer
   typedef struct packed {
      logic wr_odd;
      logic wr_even;
      logic pair_done;
   } rx_slot_t;

endpackage

// File: rtl/can_rx_filter.sv
module can_rx_filter #(
   parameter int FILT_W = 7
) (
   input  logic [FILT_W-1:0] id_upper,
   input  logic [FILT_W-1:0] filt,
   input  logic              accept_all,
   output logic              hit
);
   logic [FILT_W-1:0] diff;

   for (genvar g = 0; g < FILT_W; g++) begin : g_cmp
      assign diff[g] = id_upper[g] ^ filt[g];
   end

   assign hit = accept_all | ~(|diff);
endmodule

// File: rtl/can_rx_seq.sv
module can_rx_seq
   import can_rx_pkg::*;
#(
   parameter int DLC_W          = 4,
   parameter int MAX_BYTES      = 8,
   parameter bit ODD_TAIL_READY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hdr_vld,
   input  logic             hdr_ok,
   input  logic [DLC_W-1:0] hdr_dlc,
   input  logic             byte_vld,
   output rx_slot_t         slot
);
   localparam int CNT_W = $clog2(MAX_BYTES + 1);

   logic             active_q;
   logic [CNT_W-1:0] idx_q, len_q, len_d, idx_nxt;
   logic             take, last;

   always_comb begin
      if (int'(hdr_dlc) > MAX_BYTES) len_d = CNT_W'(MAX_BYTES);
      else                           len_d = CNT_W'(hdr_dlc);
   end

   assign take    = byte_vld & ~hdr_vld & active_q;
   assign idx_nxt = idx_q + CNT_W'(1);
   assign last    = (idx_nxt == len_q);

   assign slot.wr_odd  = take & ~idx_q[0];
   assign slot.wr_even = take &  idx_q[0];

   if (ODD_TAIL_READY) begin : g_tail
      assign slot.pair_done = slot.wr_even | (slot.wr_odd & last);
   end else begin : g_even_only
      assign slot.pair_done = slot.wr_even;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         len_q    <= '0;
      end else if (hdr_vld) begin
         active_q <= hdr_ok && (len_d != '0);
         idx_q    <= '0;
         len_q    <= len_d;
      end else if (take) begin
         idx_q <= idx_nxt;
         if (last) active_q <= 1'b0;
      end
   end
endmodule

// File: rtl/can_rx_regs.sv
module can_rx_regs
   import can_rx_pkg::*;
#(
   parameter int ID_W   = 11,
   parameter int FILT_W = 7,
   parameter int DLC_W  = 4,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [FILT_W-1:0] cfg_filter,
   input  logic              cfg_accept_all,
   input  logic              hdr_load,
   input  logic [ID_W-1:0]   hdr_id,
   input  logic [DLC_W-1:0]  hdr_dlc,
   input  rx_slot_t          slot,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic              rd_en,
   input  logic [2:0]        rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rdy_q,
   output logic              ovr_q,
   output logic [FILT_W-1:0] filt_q,
   output logic              aa_q,
   output logic [BYTE_W-1:0] idlo_q,
   output logic [BYTE_W-1:0] idhi_q
);
   localparam int LO_W  = ID_W - FILT_W;
   localparam int PAD_W = BYTE_W - FILT_W;

   logic [BYTE_W-1:0] d_odd_q, d_even_q, stat;
   logic              clr_rdy, clr_ovr;

   assign clr_rdy = rd_en && (rd_addr == RA_DATA_EVEN);
   assign clr_ovr = rd_en && (rd_addr == RA_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         filt_q <= '0;
         aa_q   <= 1'b0;
      end else if (cfg_we) begin
         filt_q <= cfg_filter;
         aa_q   <= cfg_accept_all;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idlo_q <= '0;
         idhi_q <= '0;
      end else if (hdr_load) begin
         idlo_q <= {hdr_id[LO_W-1:0], hdr_dlc};
         idhi_q <= {{PAD_W{1'b0}}, hdr_id[ID_W-1 -: FILT_W]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_odd_q  <= '0;
         d_even_q <= '0;
      end else begin
         if (slot.wr_odd)  d_odd_q  <= byte_data;
         if (slot.wr_even) d_even_q <= byte_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         rdy_q <= slot.pair_done | (rdy_q & ~clr_rdy);
         ovr_q <= (slot.pair_done & rdy_q & ~clr_rdy) | (ovr_q & ~clr_ovr);
      end
   end

   always_comb begin
      stat             = '0;
      stat[ST_RDY_BIT] = rdy_q;
      stat[ST_OVR_BIT] = ovr_q;
   end

   always_comb begin
      case (rx_addr_e'(rd_addr))
         RA_DATA_ODD:  rd_data = d_odd_q;
         RA_DATA_EVEN: rd_data = d_even_q;
         RA_ID_LO:     rd_data = idlo_q;
         RA_ID_HI:     rd_data = idhi_q;
         RA_STAT:      rd_data = stat;
         default:      rd_data = '0;
      endcase
   end
endmodule

// File: rtl/can_rx_accept.sv
module can_rx_accept
   import can_rx_pkg::*;
#(
   parameter int ID_W           = 11,
   parameter int FILT_W         = 7,
   parameter int DLC_W          = 4,
   parameter int BYTE_W         = 8,
   parameter int MAX_BYTES      = 8,
   parameter bit ODD_TAIL_READY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [FILT_W-1:0] cfg_filter,
   input  logic              cfg_accept_all,
   input  logic              hdr_vld,
   input  logic [ID_W-1:0]   hdr_id,
   input  logic [DLC_W-1:0]  hdr_dlc,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic              rd_en,
   input  logic [2:0]        rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic              byte_rdy
);
   if (FILT_W >= ID_W) begin : g_bad_filt
      $error("filter must cover fewer bits than the identifier");
   end
   if (ID_W - FILT_W + DLC_W != BYTE_W) begin : g_bad_lo
      $error("low identifier bits plus length code must fill one byte");
   end
   if (FILT_W >= BYTE_W) begin : g_bad_hi
      $error("upper identifier field must fit in one byte");
   end
   if (MAX_BYTES < 1 || MAX_BYTES >= (1 << DLC_W)) begin : g_bad_max
      $error("byte limit must be reachable by the length code");
   end

   logic              hit, hdr_load;
   rx_slot_t          slot;
   logic              rdy_q, ovr_q, aa_q;
   logic [FILT_W-1:0] filt_q;
   logic [BYTE_W-1:0] idlo_q, idhi_q;

   can_rx_filter #(.FILT_W(FILT_W)) u_filt (
      .id_upper   (hdr_id[ID_W-1 -: FILT_W]),
      .filt       (filt_q),
      .accept_all (aa_q),
      .hit        (hit)
   );

   assign hdr_load = hdr_vld & hit;

   can_rx_seq #(
      .DLC_W(DLC_W), .MAX_BYTES(MAX_BYTES), .ODD_TAIL_READY(ODD_TAIL_READY)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .hdr_vld  (hdr_vld),
      .hdr_ok   (hit),
      .hdr_dlc  (hdr_dlc),
      .byte_vld (byte_vld),
      .slot     (slot)
   );

   can_rx_regs #(
      .ID_W(ID_W), .FILT_W(FILT_W), .DLC_W(DLC_W), .BYTE_W(BYTE_W)
   ) u_regs (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_we         (cfg_we),
      .cfg_filter     (cfg_filter),
      .cfg_accept_all (cfg_accept_all),
      .hdr_load       (hdr_load),
      .hdr_id         (hdr_id),
      .hdr_dlc        (hdr_dlc),
      .slot           (slot),
      .byte_data      (byte_data),
      .rd_en          (rd_en),
      .rd_addr        (rd_addr),
      .rd_data        (rd_data),
      .rdy_q          (rdy_q),
      .ovr_q          (ovr_q),
      .filt_q         (filt_q),
      .aa_q           (aa_q),
      .idlo_q         (idlo_q),
      .idhi_q         (idhi_q)
   );

   assign byte_rdy = rdy_q;
endmodule

// File: rtl/can_rx_accept_chk.sv
module can_rx_accept_chk #(
   parameter int ID_W   = 11,
   parameter int FILT_W = 7,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hdr_vld,
   input logic [ID_W-1:0]   hdr_id,
   input logic              byte_vld,
   input logic              rd_en,
   input logic [2:0]        rd_addr,
   input logic              byte_rdy,
   input logic              ovr_q,
   input logic              aa_q,
   input logic [FILT_W-1:0] filt_q,
   input logic [BYTE_W-1:0] idlo_q,
   input logic [BYTE_W-1:0] idhi_q
);
   AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_vld && !aa_q && (hdr_id[ID_W-1 -: FILT_W] == filt_q)
      |=> idhi_q[FILT_W-1:0] == $past(hdr_id[ID_W-1 -: FILT_W])); // R2

   AST_ACCEPT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_vld && aa_q |=> idhi_q[FILT_W-1:0] == $past(hdr_id[ID_W-1 -: FILT_W])); // R3

   AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_vld && !aa_q && (hdr_id[ID_W-1 -: FILT_W] != filt_q)
      |=> $stable(idhi_q) && $stable(idlo_q)); // R4

   AST_RDY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(byte_rdy) |-> $past(byte_vld)); // R6

   AST_RDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && (rd_addr == 3'd1) && !byte_vld |=> !byte_rdy); // R7

   AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(byte_rdy) && $past(byte_vld)); // R8

   AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && (rd_addr == 3'd4) && !byte_vld |=> !ovr_q); // R8
endmodule

bind can_rx_accept can_rx_accept_chk #(
   .ID_W(ID_W), .FILT_W(FILT_W), .BYTE_W(BYTE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hdr_vld  (hdr_vld),
   .hdr_id   (hdr_id),
   .byte_vld (byte_vld),
   .rd_en    (rd_en),
   .rd_addr  (rd_addr),
   .byte_rdy (byte_rdy),
   .ovr_q    (ovr_q),
   .aa_q     (aa_q),
   .filt_q   (filt_q),
   .idlo_q   (idlo_q),
   .idhi_q   (idhi_q)
);

// File: tb/sim_can_rx_accept.sv
module sim_can_rx_accept;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_accept_all = 1'b0;
   logic [6:0]  cfg_filter = '0;
   logic        hdr_vld = 1'b0, byte_vld = 1'b0, rd_en = 1'b0;
   logic [10:0] hdr_id = '0;
   logic [3:0]  hdr_dlc = '0;
   logic [7:0]  byte_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        byte_rdy;

   int vectors = 0, fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   can_rx_accept u0 (.*);

   // ---------------- behavioural reference ----------------
   int m_d1, m_d2, m_lo, m_hi, m_filt, m_idx, m_len;
   bit m_rdy, m_ovr, m_aa, m_active;

   always @(posedge clk) begin
      bit clr2, clrs, done, hit, nov;
      if (!rst_n) begin
         m_d1 = 0; m_d2 = 0; m_lo = 0; m_hi = 0; m_filt = 0; m_idx = 0; m_len = 0;
         m_rdy = 0; m_ovr = 0; m_aa = 0; m_active = 0;
      end else begin
         clr2 = rd_en && rd_addr == 3'd1;
         clrs = rd_en && rd_addr == 3'd4;
         done = 0;
         if (hdr_vld) begin
            hit = m_aa || (int'(hdr_id) / 16 == m_filt);
            if (hit) begin
               m_lo = (int'(hdr_id) % 16) * 16 + int'(hdr_dlc);
               m_hi = int'(hdr_id) / 16;
            end
            m_len = (hdr_dlc > 8) ? 8 : int'(hdr_dlc);
            m_idx = 0;
            m_active = hit && m_len > 0;
         end else if (byte_vld && m_active) begin
            if (m_idx % 2 == 0) m_d1 = int'(byte_data); else m_d2 = int'(byte_data);
            m_idx++;
            if (m_idx % 2 == 0 || m_idx == m_len) done = 1;
            if (m_idx == m_len) m_active = 0;
         end
         nov   = (done && m_rdy && !clr2) || (m_ovr && !clrs);
         m_rdy = done || (m_rdy && !clr2);
         m_ovr = nov;
         if (cfg_we) begin m_filt = int'(cfg_filter); m_aa = cfg_accept_all; end
      end
   end

   function automatic int exp_reg(input int a);
      case (a)
         0: return m_d1;
         1: return m_d2;
         2: return m_lo;
         3: return m_hi;
         4: return int'(m_rdy) + 2 * int'(m_ovr);
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(input int a);
      case (a)
         0, 1: return "R5";
         2, 3: return "R2";
         default: return "R8";
      endcase
   endfunction

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #1;
      if (rst_n && !finished) begin
         vectors++;
         if (int'(rd_data) != exp_reg(int'(rd_addr))) begin
            fails++;
            $display("FAIL %s addr %0d got %h exp %h", tag_of(int'(rd_addr)),
                     rd_addr, rd_data, exp_reg(int'(rd_addr)));
         end
         vectors++;
         if (byte_rdy != m_rdy) begin
            fails++;
            $display("FAIL R6 byte_rdy got %0d exp %0d", byte_rdy, m_rdy);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(input bit hv, input int id, input int dlc, input bit bv,
                       input int bd, input bit re, input int ra,
                       input bit cw, input int cf, input bit ca);
      @(negedge clk);
      hdr_vld = hv; hdr_id = 11'(id); hdr_dlc = 4'(dlc);
      byte_vld = bv; byte_data = 8'(bd);
      rd_en = re; rd_addr = 3'(ra);
      cfg_we = cw; cfg_filter = 7'(cf); cfg_accept_all = ca;
      @(negedge clk);
      hdr_vld = 0; byte_vld = 0; rd_en = 0; cfg_we = 0;
   endtask

   task automatic hdr(input int id, input int dlc);
      step(1, id, dlc, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic bsend(input int b);
      step(0, 0, 0, 1, b, 0, 0, 0, 0, 0);
   endtask
   task automatic rd(input int a);
      step(0, 0, 0, 0, 0, 1, a, 0, 0, 0);
   endtask
   task automatic cfg(input int f, input bit a);
      step(0, 0, 0, 0, 0, 0, 0, 1, f, a);
   endtask

   task automatic peek(input int a, input int exp, input string tag);
      @(negedge clk);
      rd_en = 0; rd_addr = 3'(a);
      #1;
      vectors++;
      if (int'(rd_data) != exp) begin
         fails++;
         $display("FAIL %s addr %0d got %h exp %h", tag, a, rd_data, exp);
      end
   endtask

   task automatic finish_run();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      for (int a = 0; a < 8; a++) peek(a, 0, "R1");

      // R2 R5 R6: upper id bits zero match the reset filter
      hdr(11'h00F, 2);
      peek(2, 8'hF2, "R2"); peek(3, 8'h00, "R2");
      bsend(8'hAA); peek(4, 8'h00, "R6");
      bsend(8'hBB);
      peek(0, 8'hAA, "R5"); peek(1, 8'hBB, "R5"); peek(4, 8'h01, "R6");

      // R4: rejected frame changes nothing
      hdr(11'h123, 2); bsend(8'h55); bsend(8'h66);
      peek(2, 8'hF2, "R4"); peek(3, 8'h00, "R4");
      peek(0, 8'hAA, "R4"); peek(1, 8'hBB, "R4"); peek(4, 8'h01, "R4");

      // R7: only a strobed read of address 1 clears ready
      rd(0); rd(2); rd(4); peek(4, 8'h01, "R7");
      rd(1); peek(4, 8'h00, "R7");

      // R8: odd-length tail while pair pending
      cfg(7'h12, 0);
      hdr(11'h125, 3);
      peek(2, 8'h53, "R2"); peek(3, 8'h12, "R2");
      bsend(8'h11); bsend(8'h22); bsend(8'h33);
      peek(0, 8'h33, "R5"); peek(1, 8'h22, "R5"); peek(4, 8'h03, "R8");
      rd(4); peek(4, 8'h01, "R8");
      rd(1); peek(4, 8'h00, "R7");

      // R3: accept-all
      cfg(7'h12, 1);
      hdr(11'h7FF, 1);
      peek(3, 8'h7F, "R3"); peek(2, 8'hF1, "R3");
      bsend(8'h44); peek(0, 8'h44, "R6"); peek(4, 8'h01, "R6");
      rd(1);

      // R9: length code above eight
      hdr(11'h000, 12);
      for (int i = 0; i < 10; i++) bsend(8'h80 + i);
      peek(2, 8'h0C, "R9"); peek(0, 8'h86, "R9"); peek(1, 8'h87, "R9");
      peek(4, 8'h03, "R9");
      rd(4); rd(1); peek(4, 8'h00, "R8");

      // R10: config write alongside header uses old settings
      step(1, 11'h250, 1, 0, 0, 0, 0, 1, 7'h25, 0);
      peek(3, 8'h25, "R10"); peek(2, 8'h01, "R10");
      // R10: byte alongside header is dropped
      step(1, 11'h253, 2, 1, 8'hEE, 0, 0, 0, 0, 0);
      peek(2, 8'h32, "R10"); peek(0, 8'h86, "R10");
      bsend(8'h10); peek(0, 8'h10, "R10"); peek(4, 8'h00, "R10");
      // R10: completion beats a clearing read
      step(0, 0, 0, 1, 8'h20, 1, 1, 0, 0, 0);
      peek(1, 8'h20, "R10"); peek(4, 8'h01, "R10");
      rd(1);

      // mixed traffic checked every cycle against the model
      for (int n = 0; n < 600; n++) begin
         bit hv, bv, re, cw;
         hv = ($urandom % 8) == 0;
         bv = ($urandom % 2) == 0;
         re = ($urandom % 4) == 0;
         cw = ($urandom % 24) == 0;
         step(hv, int'($urandom % 4) * 16 + int'($urandom % 16), int'($urandom % 16),
              bv, int'($urandom % 256), re, int'($urandom % 8),
              cw, int'($urandom % 4), ($urandom % 4) == 0);
      end
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule